// File: doc/BRIEF.md
# Stack Frame Call/Return Trap Controller

This block manages stack frame headers when a processor calls and returns. A call takes a new frame from a linked free list and returns its address. Before the callee starts, the caller's saved caller-link is written into the caller's frame, and the single caller-link register then points at the caller. A return checks the returning frame's header. An ordinary return puts the frame back on the free list, reloads the caller-link register from the resumed frame, and says whether that frame may run at once.

Three conditions turn a request into a forced transfer instead of a fast completion:
- **Free list empty** on a call.
- **Slow return:** the return comes from a frame whose access link differs from its caller link, or whose header says so.
- **Entry trap:** the resumed frame must not run directly, because its header says so or because it is shared.

Each of these completes with a cause code. The code tells the handler whether the instruction was skipped (the unimplemented-function path) or left in place (a trap). Header words are read and written through a one-cycle synchronous memory port.

In a frame at word address `f`, the free-list/chain link is at `f-1`, the header is at `f`, and the saved caller-link is at `f+CLINK_OFS`. Address 0 means "no frame". The all-ones address is the unbound access link.

Top module: `frm_ret_trap`

## Requirements
- R1: After synchronous reset the outputs are as follows: `free_head_o` is `FREE_INIT`, `clink_o` is 0, and `busy`, `done` and `trap_req` are all 0.
- R2: A call with a non-empty free list completes without a trap. `new_frame` is the old list head, and the head becomes the word stored at head-1. The word at head-1 is overwritten with the caller address `cur_frame`. The old caller-link value is written to `cur_frame+CLINK_OFS`, and `clink_o` becomes `cur_frame`.
- R3: A call while the free-list head is 0 completes in the next cycle with `trap_cause` 1 (no free frames) and `pc_adv` 0. The head and the caller-link are unchanged.
- R4: A return whose header has the slow bit set (bit DW-2 of `cur_hdr`, the second flag of the top flag byte, ordered trap-on-entry, slow, no-push, multi-value, large, in-call, fast, reserved from the MSB down) completes in the next cycle with `trap_cause` 2 and `pc_adv` 1. No frame is freed and the caller-link is unchanged.
- R5: A return whose `cur_alink` is neither the unbound value (all ones) nor equal to `clink_o` is also treated as a slow return (cause 2). An access link equal to `clink_o` is not.
- R6: An ordinary return writes the old head into word `cur_frame-1`, and `free_head_o` becomes `cur_frame`.
- R7: An ordinary return resumes the frame that `clink_o` named. `new_frame` is that frame, and `clink_o` is reloaded from its word at +CLINK_OFS. If the resumed header has its top bit (trap on entry) set, or its use count in bits 7:0 exceeds 1, the return ends with `trap_cause` 3 and `pc_adv` 0. Otherwise it ends with no trap.
- R8: Every accepted return reports `eff_alink`. This is the old `clink_o` when `cur_alink` is all ones, and `cur_alink` otherwise.
- R9: Cause priority runs no-free-frames, then slow return, then entry trap. A slow return with a trapping caller reports cause 2 only. A call and a return requested together are served as the call.
- R10: `busy` is high through every multi-cycle header access. Requests presented while it is high are ignored and change neither the free list nor the caller-link.
- R11: `done` is a one-cycle pulse that carries the result. `trap_req` is high only together with `done`, and `done` is never high while `busy` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Call request (one cycle) |
| ret_req | input | 1 | Return request (one cycle) |
| cur_frame | input | AW | Address of the calling or returning frame |
| cur_hdr | input | DW | Header word of the returning frame |
| cur_alink | input | AW | Access link of the returning frame |
| mem_en | output | 1 | Header memory access enable |
| mem_we | output | 1 | Header memory write enable |
| mem_addr | output | AW | Header memory word address |
| mem_wdata | output | DW | Header memory write data |
| mem_rdata | input | DW | Header memory read data, one cycle after the read |
| busy | output | 1 | Sequence in progress, requests ignored |
| done | output | 1 | Request finished, results valid |
| new_frame | output | AW | Allocated frame (call) or resumed frame (return) |
| trap_req | output | 1 | Result is a forced transfer |
| trap_cause | output | 2 | 1 no free frames, 2 slow return, 3 entry trap |
| pc_adv | output | 1 | PC steps past the instruction |
| eff_alink | output | AW | Effective access link of the last return |
| clink_o | output | AW | Caller-link register |
| free_head_o | output | AW | Free-list head register |

## Verification
Calls are driven from a fresh list, a partly used list and an exhausted list. This separates the pop path from the no-free-frames path and shows the caller-link save. Returns vary three inputs independently: the slow flag, the access link (unbound, equal to the caller-link, or foreign) and the resumed header (trap bit, use count 0 to 2). This separates the slow path from the freeing path, and an entry trap from a plain resume. Requests injected during busy, and a call and return presented together, tell ignored requests and arbitration apart from served ones.

// File: rtl/frm_pkg.sv
package frm_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_NOFREE = 2'd1,
    CAUSE_SLOW   = 2'd2,
    CAUSE_ENTRY  = 2'd3
  } trap_cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_C_RD,
    ST_C_WR,
    ST_C_SAVE,
    ST_R_WR,
    ST_R_RDH,
    ST_R_RDC,
    ST_R_END
  } ctl_state_e;

endpackage

// File: rtl/frm_link_regs.sv
module frm_link_regs #(
  parameter int AW        = 10,
  parameter int FREE_INIT = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          head_ld,
  input  logic [AW-1:0] head_d,
  input  logic          link_ld,
  input  logic [AW-1:0] link_d,
  output logic [AW-1:0] head_q,
  output logic [AW-1:0] link_q
);

  localparam logic [AW-1:0] HEAD_RST = AW'(FREE_INIT);

  // Free-list head: popped on call, pushed on ordinary return
  always_ff @(posedge clk) begin
    if (rst)          head_q <= HEAD_RST;
    else if (head_ld) head_q <= head_d;
  end

  // Single caller-link register, valid for the shallowest frame only
  always_ff @(posedge clk) begin
    if (rst)          link_q <= '0;
    else if (link_ld) link_q <= link_d;
  end

endmodule

// File: rtl/frm_trap_arb.sv
module frm_trap_arb
  import frm_pkg::*;
(
  input  logic        nofree,
  input  logic        slow,
  input  logic        entry,
  output trap_cause_e cause,
  output logic        pc_adv
);

  // Fixed priority; only the handler-call path skips the instruction
  always_comb begin
    cause  = CAUSE_NONE;
    pc_adv = 1'b0;
    if (nofree) begin
      cause = CAUSE_NOFREE;
    end else if (slow) begin
      cause  = CAUSE_SLOW;
      pc_adv = 1'b1;
    end else if (entry) begin
      cause = CAUSE_ENTRY;
    end
  end

endmodule

// File: rtl/frm_ctl.sv
module frm_ctl
  import frm_pkg::*;
#(
  parameter int AW        = 10,
  parameter int DW        = 32,
  parameter int CLINK_OFS = 5,
  parameter int USE_W     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          call_req,
  input  logic          ret_req,
  input  logic [AW-1:0] cur_frame,
  input  logic [DW-1:0] cur_hdr,
  input  logic [AW-1:0] cur_alink,
  input  logic [DW-1:0] mem_rdata,
  input  logic [AW-1:0] head_q,
  input  logic [AW-1:0] link_q,
  output logic          head_ld,
  output logic [AW-1:0] head_d,
  output logic          link_ld,
  output logic [AW-1:0] link_d,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          done,
  output logic          trap_req,
  output trap_cause_e   trap_cause,
  output logic          pc_adv,
  output logic [AW-1:0] new_frame,
  output logic [AW-1:0] eff_alink
);

  localparam int              T_BIT   = DW - 1;
  localparam int              S_BIT   = DW - 2;
  localparam logic [AW-1:0]   OFS_A   = AW'(CLINK_OFS);
  localparam logic [AW-1:0]   ONE_A   = AW'(1);
  localparam logic [AW-1:0]   UNBOUND = '1;
  localparam logic [USE_W-1:0] USE_ONE = USE_W'(1);

  ctl_state_e    state;
  logic [AW-1:0] op_frame;
  logic [AW-1:0] tgt;
  logic          ent_q;

  logic take_call, take_ret;
  logic slow_cond;
  logic nofree_ev, slow_ev, entry_ev, finish;
  trap_cause_e cause_a;
  logic        adv_a;
  logic        unused_bits;

  assign unused_bits = &{1'b0, cur_hdr, mem_rdata};

  assign take_call = (state == ST_IDLE) && call_req;
  assign take_ret  = (state == ST_IDLE) && !call_req && ret_req;
  assign slow_cond = cur_hdr[S_BIT] ||
                     ((cur_alink != UNBOUND) && (cur_alink != link_q));

  assign nofree_ev = take_call && (head_q == '0);
  assign slow_ev   = take_ret && slow_cond;
  assign entry_ev  = (state == ST_R_END) && ent_q;
  assign finish    = nofree_ev || slow_ev ||
                     (state == ST_C_SAVE) || (state == ST_R_END);

  frm_trap_arb u_arb (
    .nofree (nofree_ev),
    .slow   (slow_ev),
    .entry  (entry_ev),
    .cause  (cause_a),
    .pc_adv (adv_a)
  );

  assign busy = (state != ST_IDLE);

  // Register updates for free-list head and caller-link
  always_comb begin
    head_ld = 1'b0;
    head_d  = op_frame;
    link_ld = 1'b0;
    link_d  = op_frame;
    unique case (state)
      ST_C_WR: begin
        head_ld = 1'b1;
        head_d  = mem_rdata[AW-1:0];
      end
      ST_C_SAVE: link_ld = 1'b1;
      ST_R_WR:   head_ld = 1'b1;
      ST_R_END: begin
        link_ld = 1'b1;
        link_d  = mem_rdata[AW-1:0];
      end
      default: ;
    endcase
  end

  // Header memory port, driven from state registers
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_C_RD: begin
        mem_en   = 1'b1;
        mem_addr = tgt - ONE_A;
      end
      ST_C_WR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = tgt - ONE_A;
        mem_wdata = DW'(op_frame);
      end
      ST_C_SAVE: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = op_frame + OFS_A;
        mem_wdata = DW'(link_q);
      end
      ST_R_WR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = op_frame - ONE_A;
        mem_wdata = DW'(head_q);
      end
      ST_R_RDH: begin
        mem_en   = 1'b1;
        mem_addr = tgt;
      end
      ST_R_RDC: begin
        mem_en   = 1'b1;
        mem_addr = tgt + OFS_A;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      op_frame   <= '0;
      tgt        <= '0;
      ent_q      <= 1'b0;
      done       <= 1'b0;
      trap_req   <= 1'b0;
      trap_cause <= CAUSE_NONE;
      pc_adv     <= 1'b0;
      new_frame  <= '0;
      eff_alink  <= '0;
    end else begin
      done       <= finish;
      trap_req   <= finish && (cause_a != CAUSE_NONE);
      trap_cause <= finish ? cause_a : CAUSE_NONE;
      pc_adv     <= finish && adv_a;
      unique case (state)
        ST_IDLE: begin
          if (take_call && !nofree_ev) begin
            op_frame <= cur_frame;
            tgt      <= head_q;
            state    <= ST_C_RD;
          end else if (take_ret) begin
            eff_alink <= (cur_alink == UNBOUND) ? link_q : cur_alink;
            if (!slow_cond) begin
              op_frame <= cur_frame;
              tgt      <= link_q;
              state    <= ST_R_WR;
            end
          end
        end
        ST_C_RD:   state <= ST_C_WR;
        ST_C_WR:   state <= ST_C_SAVE;
        ST_C_SAVE: begin
          new_frame <= tgt;
          state     <= ST_IDLE;
        end
        ST_R_WR:   state <= ST_R_RDH;
        ST_R_RDH:  state <= ST_R_RDC;
        ST_R_RDC: begin
          ent_q <= mem_rdata[T_BIT] || (mem_rdata[USE_W-1:0] > USE_ONE);
          state <= ST_R_END;
        end
        ST_R_END: begin
          new_frame <= tgt;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/frm_ret_trap.sv
module frm_ret_trap
  import frm_pkg::*;
#(
  parameter int AW        = 10,
  parameter int DW        = 32,
  parameter int CLINK_OFS = 5,
  parameter int FREE_INIT = 24,
  parameter int USE_W     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          call_req,
  input  logic          ret_req,
  input  logic [AW-1:0] cur_frame,
  input  logic [DW-1:0] cur_hdr,
  input  logic [AW-1:0] cur_alink,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] new_frame,
  output logic          trap_req,
  output logic [1:0]    trap_cause,
  output logic          pc_adv,
  output logic [AW-1:0] eff_alink,
  output logic [AW-1:0] clink_o,
  output logic [AW-1:0] free_head_o
);

  logic          head_ld, link_ld;
  logic [AW-1:0] head_d, link_d, head_q, link_q;
  trap_cause_e   cause_w;

  frm_link_regs #(.AW(AW), .FREE_INIT(FREE_INIT)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .head_ld (head_ld),
    .head_d  (head_d),
    .link_ld (link_ld),
    .link_d  (link_d),
    .head_q  (head_q),
    .link_q  (link_q)
  );

  frm_ctl #(.AW(AW), .DW(DW), .CLINK_OFS(CLINK_OFS), .USE_W(USE_W)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .call_req   (call_req),
    .ret_req    (ret_req),
    .cur_frame  (cur_frame),
    .cur_hdr    (cur_hdr),
    .cur_alink  (cur_alink),
    .mem_rdata  (mem_rdata),
    .head_q     (head_q),
    .link_q     (link_q),
    .head_ld    (head_ld),
    .head_d     (head_d),
    .link_ld    (link_ld),
    .link_d     (link_d),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .busy       (busy),
    .done       (done),
    .trap_req   (trap_req),
    .trap_cause (cause_w),
    .pc_adv     (pc_adv),
    .new_frame  (new_frame),
    .eff_alink  (eff_alink)
  );

  assign trap_cause  = cause_w;
  assign clink_o     = link_q;
  assign free_head_o = head_q;

endmodule

// File: rtl/frm_ret_trap_chk.sv
module frm_ret_trap_chk #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          call_req,
  input logic          ret_req,
  input logic [DW-1:0] cur_hdr,
  input logic          busy,
  input logic          done,
  input logic          trap_req,
  input logic [1:0]    trap_cause,
  input logic          pc_adv,
  input logic [AW-1:0] clink_o,
  input logic [AW-1:0] free_head_o
);

  logic unused_hdr;
  assign unused_hdr = &{1'b0, cur_hdr};

  // R11: a trap is only reported with completion
  a_r11_trap_with_done: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> done);

  // R11: completion never overlaps a running sequence
  a_r11_no_done_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  // R3: empty free list turns a call into a no-free-frames trap
  a_r3_nofree_trap: assert property (@(posedge clk) disable iff (rst)
    (!busy && call_req && free_head_o == '0) |=>
      (done && trap_req && trap_cause == 2'd1 && !pc_adv &&
       $stable(free_head_o) && $stable(clink_o)));

  // R4: slow flag makes a return a handler call that skips the instruction
  a_r4_slow_ufn: assert property (@(posedge clk) disable iff (rst)
    (!busy && !call_req && ret_req && cur_hdr[DW-2]) |=>
      (done && trap_req && trap_cause == 2'd2 && pc_adv &&
       $stable(free_head_o) && $stable(clink_o)));

  // R7: an entry trap leaves the PC in place
  a_r7_entry_no_adv: assert property (@(posedge clk) disable iff (rst)
    (done && trap_cause == 2'd3) |-> !pc_adv);

endmodule

bind frm_ret_trap frm_ret_trap_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .call_req    (call_req),
  .ret_req     (ret_req),
  .cur_hdr     (cur_hdr),
  .busy        (busy),
  .done        (done),
  .trap_req    (trap_req),
  .trap_cause  (trap_cause),
  .pc_adv      (pc_adv),
  .clink_o     (clink_o),
  .free_head_o (free_head_o)
);

// File: tb/tb_frm_ret_trap.sv
`timescale 1ns/1ps
module tb_frm_ret_trap;

  localparam int AW = 10;
  localparam int DW = 32;
  localparam int OFS = 5;
  localparam int FINIT = 24;
  localparam logic [AW-1:0] UNB = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic call_req = 1'b0, ret_req = 1'b0;
  logic [AW-1:0] cur_frame = '0, cur_alink = '0;
  logic [DW-1:0] cur_hdr = '0;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic busy, done, trap_req, pc_adv;
  logic [1:0] trap_cause;
  logic [AW-1:0] new_frame, eff_alink, clink_o, free_head_o;

  logic [DW-1:0] mem [0:(1<<AW)-1];

  always #2.5 clk = ~clk;

  frm_ret_trap dut (
    .clk(clk), .rst(rst), .call_req(call_req), .ret_req(ret_req),
    .cur_frame(cur_frame), .cur_hdr(cur_hdr), .cur_alink(cur_alink),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .new_frame(new_frame), .trap_req(trap_req),
    .trap_cause(trap_cause), .pc_adv(pc_adv), .eff_alink(eff_alink),
    .clink_o(clink_o), .free_head_o(free_head_o)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [AW-1:0] e_head, e_link;
  logic r_trap, r_adv, saw_busy, timed_out;
  logic [1:0] r_cause;
  logic [AW-1:0] r_new, r_eff;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] frm(input int k);
    return AW'(16 * k + 8);
  endfunction

  function automatic logic [1:0] resume_cause(input logic [DW-1:0] h);
    return (h[DW-1] || (h[7:0] > 8'd1)) ? 2'd3 : 2'd0;
  endfunction

  // Pulse a request, wait for done; optionally inject a return while busy
  task automatic run_op(input bit c, input bit r, input logic [AW-1:0] f,
                        input logic [DW-1:0] h, input logic [AW-1:0] a, input bit inj);
    int wait_n;
    @(negedge clk);
    call_req = c; ret_req = r; cur_frame = f; cur_hdr = h; cur_alink = a;
    @(negedge clk);
    call_req = 0; ret_req = 0;
    saw_busy = 0; timed_out = 0; wait_n = 0;
    while (!done && wait_n < 40) begin
      if (busy) saw_busy = 1;
      if (inj && busy && wait_n == 1) begin
        ret_req = 1; cur_frame = frm(33); cur_hdr = '0; cur_alink = UNB;
      end else begin
        ret_req = 0;
      end
      @(negedge clk);
      wait_n++;
    end
    ret_req = 0;
    if (!done) begin
      timed_out = 1;
      chk("R11 done timeout", 0, 1);
    end
    r_trap = trap_req; r_cause = trap_cause; r_adv = pc_adv;
    r_new = new_frame; r_eff = eff_alink;
    @(negedge clk);
    chk("R11 done pulse width", done, 0);
  endtask

  task automatic do_call(input logic [AW-1:0] f, input bit inj, input bit both);
    logic [AW-1:0] oh, ol, nx;
    oh = e_head; ol = e_link;
    nx = (oh != 0) ? mem[oh - 1][AW-1:0] : '0;
    run_op(1, both, f, 32'h4000_0000, UNB, inj);
    if (oh == 0) begin
      chk("R3 trap", r_trap, 1);
      chk("R3 cause", r_cause, 1);
      chk("R3 pc_adv", r_adv, 0);
      chk("R3 head", free_head_o, oh);
      chk("R3 clink", clink_o, ol);
    end else begin
      chk("R2 no trap", r_trap, 0);
      chk("R2 new_frame", r_new, oh);
      chk("R2 head pop", free_head_o, nx);
      chk("R2 clink", clink_o, f);
      chk("R2 callee link word", mem[oh - 1], DW'(f));
      chk("R2 saved clink", mem[f + AW'(OFS)], DW'(ol));
      if (inj || both) chk("R10 busy seen", saw_busy, 1);
      e_head = nx; e_link = f;
    end
    if (inj || both) begin
      repeat (3) @(negedge clk);
      chk("R10 ignored head", free_head_o, e_head);
      chk("R10 ignored clink", clink_o, e_link);
    end
  endtask

  task automatic do_ret(input logic [AW-1:0] f, input logic [DW-1:0] h,
                        input logic [AW-1:0] a, input logic [DW-1:0] rh,
                        input logic [AW-1:0] rl);
    logic slow;
    logic [AW-1:0] oh, ol;
    oh = e_head; ol = e_link;
    mem[ol] = rh;
    mem[ol + AW'(OFS)] = DW'(rl);
    slow = h[DW-2] || (a != UNB && a != ol);
    run_op(0, 1, f, h, a, 0);
    chk("R8 eff_alink", r_eff, (a == UNB) ? ol : a);
    if (slow) begin
      chk("R4/R5 slow trap", r_trap, 1);
      chk("R4/R5 cause (R9 priority)", r_cause, 2);
      chk("R4/R5 pc_adv", r_adv, 1);
      chk("R4 head kept", free_head_o, oh);
      chk("R4 clink kept", clink_o, ol);
    end else begin
      chk("R6 freed link word", mem[f - 1], DW'(oh));
      chk("R6 head push", free_head_o, f);
      chk("R7 resumed frame", r_new, ol);
      chk("R7 clink reload", clink_o, rl);
      chk("R7 cause", r_cause, resume_cause(rh));
      chk("R7 trap", r_trap, resume_cause(rh) != 0);
      chk("R7 pc_adv", r_adv, 0);
      e_head = f; e_link = rl;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    for (int k = 1; k <= 8; k++) mem[frm(k) - 1] = (k < 8) ? DW'(frm(k + 1)) : '0;
    e_head = AW'(FINIT); e_link = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 head", free_head_o, FINIT);
    chk("R1 clink", clink_o, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 trap", trap_req, 0);

    // Directed corner cases
    do_call(frm(20), 0, 0);                                   // R2
    do_ret(frm(21), 32'h0, UNB, 32'h0000_0001, frm(22));       // R6 R7 R8
    do_ret(frm(23), 32'h4000_0000, UNB, 32'h8000_0000, frm(24)); // R4 R9
    do_ret(frm(25), 32'h0, e_link, 32'h0, frm(26));            // R5 equal link
    do_ret(frm(27), 32'h0, frm(30), 32'h0, frm(28));           // R5 foreign link
    do_ret(frm(29), 32'h0, UNB, 32'h8000_0000, frm(31));       // R7 T set
    do_ret(frm(32), 32'h0, UNB, 32'h0000_0002, frm(34));       // R7 use count 2
    do_call(frm(35), 1, 0);                                   // R10 inject
    do_call(frm(36), 0, 1);                                   // R9 call wins
    while (e_head != 0) do_call(frm(37), 0, 0);
    do_call(frm(38), 0, 0);                                   // R3

    // Constrained random mix
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] f, a, rl;
      logic [DW-1:0] h, rh;
      f = frm(1 + int'($urandom % 40));
      if ($urandom % 2 == 0) begin
        do_call(f, 0, 0);
      end else begin
        h = $urandom;
        h[DW-2] = ($urandom % 4 == 0);
        case ($urandom % 3)
          0: a = UNB;
          1: a = e_link;
          default: a = frm(1 + int'($urandom % 40));
        endcase
        rh = $urandom;
        rh[DW-1] = ($urandom % 4 == 0);
        rh[7:0] = 8'($urandom % 3);
        rl = frm(1 + int'($urandom % 40));
        do_ret(f, h, a, rh, rl);
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule